// File: doc/BRIEF.md
# Ratio-Selectable Clock Enable Generator

This block runs on a double-rate reference clock. It produces two enables that a processor uses to choose which of its internal clock edges take effect. The core enable alternates on every reference cycle, so it runs at half the reference rate. The bus enable repeats once every one, two, three or four core periods, as set by a 2-bit ratio input. It has a fixed high/low split for each ratio. Both enables come from flops on the reference clock. A bus-enable rising edge therefore always falls on a reference edge, and always together with a core-enable rising edge.

A bus cycle is one repetition of the bus-enable pattern. The ratio input is sampled only when a new bus cycle begins. An in-flight bus cycle always finishes with the ratio that started it. Reset aligns both enables, so the first cycle after reset is the first cycle of a bus cycle and of a core period.

Top module: `clken_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both enables are 0 after that edge. In the first cycle after `rst` is released, both enables are 1.
- R2: Counting cycles from t=0 after reset, `core_en` is 1 when t is even and 0 when t is odd, toggling at every edge.
- R3: With `ratio_sel` = 2'b00 (1x), `bus_en` is identical to `core_en` in every cycle.
- R4: With `ratio_sel` = 2'b01 (1/2), `bus_en` repeats every 4 cycles: high for 2, then low for 2.
- R5: With `ratio_sel` = 2'b10 (1/3), `bus_en` repeats every 6 cycles: high for 4, then low for 2 (66/33).
- R6: With `ratio_sel` = 2'b11 (1/4), `bus_en` repeats every 8 cycles: high for 6, then low for 2 (75/25).
- R7: `bus_en` rises only in a cycle where `core_en` also rises. It never changes other than at a reference edge.
- R8: `ratio_sel` is sampled only at the edge that starts a bus cycle. A change made part-way through a bus cycle leaves that cycle's pattern unchanged and applies from the next bus cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate reference clock |
| rst | input | 1 | Synchronous active-high reset; phase-aligns both enables |
| ratio_sel | input | 2 | Bus ratio: 00=1x, 01=1/2, 10=1/3, 11=1/4 of core rate |
| core_en | output | 1 | Core edge enable, half the reference rate |
| bus_en | output | 1 | Bus edge enable, at the selected ratio and duty |

## Verification
Each of the four ratio codes is first held constant for several full bus cycles after reset. This tells the four period and duty combinations apart, and shows that the 1x code tracks the core enable exactly. Every ordered pair of ratio codes is then switched in two ways. One switch lands exactly on the edge that starts a bus cycle, so the new ratio takes effect at once. The other lands one cycle later, so the old pattern must run to completion first. Together these separate a design that samples the ratio only at bus-cycle starts from one that samples it at other times. In every cycle the bench also compares the alignment of a bus-enable rise against the core enable.

// File: rtl/clken_pkg.sv
package clken_pkg;

  // Bus cycle length in reference cycles for a ratio code (code+1 core periods).
  function automatic int bus_period(input int code);
    return 2 * (code + 1);
  endfunction

  // Number of leading reference cycles in a bus cycle where the bus enable is high.
  // 1x: one cycle; slower ratios: all but the final two cycles.
  function automatic int bus_high_len(input int code);
    return (code == 0) ? 1 : 2 * code;
  endfunction

endpackage

// File: rtl/clken_core_phase.sv
module clken_core_phase (
  input  logic clk,
  input  logic rst,
  output logic core_en
);

  logic core_q;

  always_ff @(posedge clk) begin
    if (rst) core_q <= 1'b0;
    else     core_q <= ~core_q;
  end

  assign core_en = core_q;

  // R2: the core enable alternates at every reference edge once out of reset
  assert_core_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (core_q != $past(core_q)));

endmodule

// File: rtl/clken_bus_phase.sv
module clken_bus_phase
  import clken_pkg::*;
#(
  parameter int SEL_W = 2,
  localparam int MAX_PERIOD = 2 * (1 << SEL_W),
  localparam int PW = $clog2(MAX_PERIOD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             bus_en,
  output logic             cycle_start
);

  logic             started_q;
  logic [SEL_W-1:0] ratio_q;
  logic [PW-1:0]    pos_q;
  logic             bus_q;

  logic             at_boundary;
  logic             load;
  logic [SEL_W-1:0] ratio_d;
  logic [PW-1:0]    pos_d;
  logic             bus_d;

  // Last reference cycle of the running bus cycle.
  assign at_boundary = started_q &&
                       (int'(pos_q) == bus_period(int'(ratio_q)) - 1);
  assign load        = !started_q || at_boundary;
  assign ratio_d     = load ? ratio_sel : ratio_q;
  assign pos_d       = load ? '0 : pos_q + PW'(1);
  assign bus_d       = int'(pos_d) < bus_high_len(int'(ratio_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      ratio_q   <= '0;
      pos_q     <= '0;
      bus_q     <= 1'b0;
    end else begin
      started_q <= 1'b1;
      ratio_q   <= ratio_d;
      pos_q     <= pos_d;
      bus_q     <= bus_d;
    end
  end

  assign bus_en      = bus_q;
  assign cycle_start = started_q && (pos_q == '0);

  // R8: the active ratio may only change at an edge that opens a new bus cycle
  assert_ratio_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (started_q && !at_boundary) |=> $stable(ratio_q));

  // R4 R5 R6: outside 1x the low phase always lasts two reference cycles
  assert_low_two_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_q) && ratio_q != '0) |=> !bus_q);

  // R1: every bus cycle starts with the enable high
  assert_start_high_R1: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> bus_q);

endmodule

// File: rtl/clken_gen.sv
module clken_gen #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             core_en,
  output logic             bus_en
);

  logic core_w;
  logic bus_w;
  logic bus_cycle_start;

  clken_core_phase u_core (
    .clk     (clk),
    .rst     (rst),
    .core_en (core_w)
  );

  clken_bus_phase #(.SEL_W(SEL_W)) u_bus (
    .clk         (clk),
    .rst         (rst),
    .ratio_sel   (ratio_sel),
    .bus_en      (bus_w),
    .cycle_start (bus_cycle_start)
  );

  assign core_en = core_w;
  assign bus_en  = bus_w;

  // R7: a bus-enable rise is always accompanied by a core-enable rise
  assert_bus_rise_aligned_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_w) |-> $rose(core_w));

  // R7: a new bus cycle starts only in a core-high cycle
  assert_start_on_core_R7: assert property (@(posedge clk) disable iff (rst)
    bus_cycle_start |-> core_w);

  // R1: reset clears both enables at the next edge
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!core_w && !bus_w));

endmodule

// File: tb/clken_gen_test.sv
module clken_gen_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ratio_sel = 2'b00;
  logic       core_en;
  logic       bus_en;

  int checks = 0;
  int fails  = 0;

  always #2ns clk = ~clk;   // 250 MHz

  clken_gen uut (
    .clk       (clk),
    .rst       (rst),
    .ratio_sel (ratio_sel),
    .core_en   (core_en),
    .bus_en    (bus_en)
  );

  task automatic check(input logic got, input logic exp, input string req, input int t);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s t=%0d got=%0b expected=%0b", req, t, got, exp);
    end
  endtask

  // Expected bus enable at offset p into a bus cycle of d core periods.
  function automatic logic exp_bus(input int d, input int p);
    if (d == 1) return (p == 0);
    return (p < 2 * d - 2);
  endfunction

  function automatic string ratio_req(input int code);
    case (code)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Reset with ratio a, switch to b so that the edge producing cycle c sees b.
  task automatic run_pair(input int a, input int b, input int c, input int len);
    int da, db, pa, pb, t0;
    logic prev_core, prev_bus;
    da = a + 1; db = b + 1; pa = 2 * da; pb = 2 * db;
    t0 = ((c + pa - 1) / pa) * pa;
    @(negedge clk);
    rst = 1'b1;
    ratio_sel = 2'(a);
    repeat (3) begin
      @(negedge clk);
      check(core_en, 1'b0, "R1", -1);
      check(bus_en, 1'b0, "R1", -1);
    end
    rst = 1'b0;
    prev_core = 1'b0; prev_bus = 1'b0;
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      if (t == 0) check(bus_en & core_en, 1'b1, "R1", t);
      check(core_en, (t % 2 == 0), "R2", t);
      if (t < t0)
        check(bus_en, exp_bus(da, t % pa), (a == b) ? ratio_req(a) : "R8", t);
      else
        check(bus_en, exp_bus(db, (t - t0) % pb), (a == b) ? ratio_req(b) : "R8", t);
      if (a == 0 && t < t0) check(bus_en, core_en, "R3", t);
      if (!prev_bus && bus_en) check(!prev_core && core_en, 1'b1, "R7", t);
      prev_core = core_en; prev_bus = bus_en;
      if (t + 1 == c) ratio_sel = 2'(b);
    end
  endtask

  initial begin
    #(4ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // Steady ratios R3..R6 plus ratio switches R8 (on and off a bus-cycle start)
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        for (int off = 0; off < 2; off++) begin
          int pa;
          pa = 2 * (a + 1);
          run_pair(a, b, pa + off, 2 * pa + 3 * 2 * (b + 1) + 2);
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule